// File: doc/BRIEF.md
# Dual-Buffer Receive DMA Tracker

This block follows the progress of a serial receiver's DMA engine as it fills two alternating memory buffers, called A and B. For each buffer it keeps a byte offset that names the next location to be written. It also holds a sticky record of where the first damaged byte landed. Every accepted byte produces a memory write strobe and an address, formed from the buffer's base address plus its current offset. When a buffer reaches its programmed length it unloads, and the next byte goes to the other buffer if that one is loaded.

Error records cover parity, framing and receive-FIFO overrun faults. An overrun is seen where bytes enter the FIFO, which sits several bytes ahead of the DMA. For that reason the recorded offset of an overrun is pulled back by the FIFO depth. In SPI slave mode the tracker takes one snapshot of the active buffer's offset when the active-low select line is released. A DMA reset clears the tracking state and allows one more snapshot.

Top module: `rxdma_dualbuf_tracker`

## Requirements
- R1: While a buffer is loaded, each byte written to it raises `mem_we` in the same cycle. The address is `base + offset`. After the clock edge that buffer's 13-bit offset is one higher.
- R2: A `load_req` pulse for a buffer loads it, sets its offset to zero and sets its error offset to zero.
- R3: A `cnt_wr` pulse sets a buffer's offset to `cnt_wdata`. If the buffer was unloaded, it becomes loaded and its error record is cleared. If it was already loaded, its error record is kept.
- R4: A byte goes to the active buffer if that buffer is loaded, and otherwise to the other buffer (`mem_buf` 0 = A, 1 = B). The byte that brings an offset up to the buffer's length unloads that buffer (`loaded` bit 0 = A, bit 1 = B) and makes the other buffer active.
- R5: With `spi_slave` high, the first rising edge of `ssel_n` copies the active buffer's offset into `saved_cnt`. Later rising edges leave it unchanged.
- R6: The first byte flagged with a parity or framing error records its own offset. A byte flagged with an overrun records its offset minus 4 (the FIFO depth), with a floor of zero. The error offset reads zero when no error has been seen.
- R7: Once a buffer's error record is set, later errors leave it unchanged. Only a load, a reload through `cnt_wr` of an unloaded buffer, or a DMA reset clears it.
- R8: All readable registers are zero after reset. Their bits 31 to 13 always read zero.
- R9: `dma_rst` clears both offsets, both error records, both loaded flags and `drop_ovf`, and makes A active. It also re-arms the snapshot, so the next qualifying release captures again. `saved_cnt` keeps its value.
- R10: A byte that arrives while neither buffer is loaded is dropped: `mem_we` stays low and `drop_ovf` sets and stays set until `dma_rst`.
- R11: Within a buffer, same-cycle controls take effect in this order: `dma_rst` first, then `cnt_wr`, then `load_req`, then `unload_req` (which unloads the buffer), and a byte last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_rst | input | 1 | Synchronous receive DMA reset |
| load_req | input | 2 | Load pulse per buffer (bit 0 = A) |
| unload_req | input | 2 | Unload pulse per buffer |
| cnt_wr | input | 2 | Offset register write strobe per buffer |
| cnt_wdata | input | 13 | Offset write data |
| len_a | input | 13 | Length of buffer A in bytes |
| len_b | input | 13 | Length of buffer B in bytes |
| base_a | input | 16 | Base address of buffer A |
| base_b | input | 16 | Base address of buffer B |
| rx_valid | input | 1 | Received byte strobe |
| rx_par_err | input | 1 | Byte carries a parity error |
| rx_frm_err | input | 1 | Byte carries a framing error |
| rx_ovf_err | input | 1 | Byte is flagged with a FIFO overrun |
| spi_slave | input | 1 | SPI slave mode enable |
| ssel_n | input | 1 | Active-low slave select |
| rx_cnt_a | output | 32 | Offset of buffer A |
| rx_cnt_b | output | 32 | Offset of buffer B |
| err_off_a | output | 32 | First-error offset of buffer A |
| err_off_b | output | 32 | First-error offset of buffer B |
| saved_cnt | output | 32 | Offset captured at select release |
| loaded | output | 2 | Loaded flag per buffer |
| drop_ovf | output | 1 | Sticky dropped-byte flag |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory write address |
| mem_buf | output | 1 | Buffer targeted by the write |

## Verification
Some rules are checked on every cycle. Writes never go to an unloaded buffer. Offsets step by exactly one per stored byte. Load, write and DMA reset clear or set the registers as required. A set error record holds still. The snapshot changes only on a select release in slave mode, and a byte with no loaded buffer sets the drop flag. Other behaviour is shown only by the bench's scenarios: which offset is recorded for each kind of error (including the overrun back-off and its floor at zero), handover between buffers at the programmed length, the one-shot snapshot and its re-arming, and the order of precedence between same-cycle controls.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
   typedef enum logic {
      BUF_A = 1'b0,
      BUF_B = 1'b1
   } rxdma_buf_e;

   typedef struct packed {
      logic parity;
      logic framing;
      logic overrun;
   } rxdma_flags_t;

   localparam int unsigned RXDMA_NBUF = 2;
endpackage

// File: rtl/rxdma_route.sv
module rxdma_route
   import rxdma_pkg::*;
#(
   parameter int unsigned CNT_W  = 13,
   parameter int unsigned ADDR_W = 16
) (
   input  logic              rx_valid,
   input  rxdma_buf_e        active,
   input  logic [1:0]        loaded,
   input  logic [CNT_W-1:0]  cnt_a,
   input  logic [CNT_W-1:0]  cnt_b,
   input  logic [ADDR_W-1:0] base_a,
   input  logic [ADDR_W-1:0] base_b,
   output logic              hit,
   output rxdma_buf_e        target,
   output logic [ADDR_W-1:0] addr
);
   logic [CNT_W-1:0]  tgt_cnt;
   logic [ADDR_W-1:0] tgt_base;

   always_comb begin
      if (loaded[active]) begin
         target = active;
      end else begin
         target = (active == BUF_A) ? BUF_B : BUF_A;
      end
      hit      = rx_valid && loaded[target];
      tgt_cnt  = (target == BUF_B) ? cnt_b : cnt_a;
      tgt_base = (target == BUF_B) ? base_b : base_a;
      addr     = tgt_base + ADDR_W'(tgt_cnt);
   end
endmodule

// File: rtl/rxdma_buf_slot.sv
module rxdma_buf_slot
   import rxdma_pkg::*;
#(
   parameter int unsigned CNT_W      = 13,
   parameter int unsigned FIFO_DEPTH = 4,
   parameter bit          OVF_SAT    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dma_rst,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             load,
   input  logic             unload,
   input  logic             byte_we,
   input  rxdma_flags_t     flags,
   input  logic [CNT_W-1:0] len,
   output logic [CNT_W-1:0] cnt,
   output logic             loaded,
   output logic [CNT_W-1:0] err_off,
   output logic             last
);
   localparam logic [CNT_W-1:0] BACK = CNT_W'(FIFO_DEPTH);

   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] ovf_off;
   logic [CNT_W-1:0] hit_off;
   logic             err_set;
   logic             err_any;

   assign cnt_inc = cnt + 1'b1;
   assign last    = (cnt_inc == len);
   assign err_any = |flags;

   generate
      if (OVF_SAT) begin : g_sat
         assign ovf_off = (cnt >= BACK) ? (cnt - BACK) : '0;
      end else begin : g_wrap
         assign ovf_off = cnt - BACK;
      end
   endgenerate

   assign hit_off = flags.overrun ? ovf_off : cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         loaded  <= 1'b0;
         err_off <= '0;
         err_set <= 1'b0;
      end else if (dma_rst) begin
         cnt     <= '0;
         loaded  <= 1'b0;
         err_off <= '0;
         err_set <= 1'b0;
      end else if (wr_en) begin
         cnt    <= wr_data;
         loaded <= 1'b1;
         if (!loaded) begin
            err_off <= '0;
            err_set <= 1'b0;
         end
      end else if (load) begin
         cnt     <= '0;
         loaded  <= 1'b1;
         err_off <= '0;
         err_set <= 1'b0;
      end else if (unload) begin
         loaded <= 1'b0;
      end else if (byte_we) begin
         cnt <= cnt_inc;
         if (last) begin
            loaded <= 1'b0;
         end
         if (err_any && !err_set) begin
            err_off <= hit_off;
            err_set <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/rxdma_ssel_snap.sv
module rxdma_ssel_snap #(
   parameter int unsigned CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dma_rst,
   input  logic             spi_slave,
   input  logic             ssel_n,
   input  logic [CNT_W-1:0] cur_cnt,
   output logic [CNT_W-1:0] saved
);
   logic ssel_q;
   logic armed;
   logic release_edge;

   assign release_edge = spi_slave && ssel_n && !ssel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ssel_q <= 1'b1;
         armed  <= 1'b1;
         saved  <= '0;
      end else begin
         ssel_q <= ssel_n;
         if (dma_rst) begin
            armed <= 1'b1;
         end else if (release_edge && armed) begin
            saved <= cur_cnt;
            armed <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/rxdma_dualbuf_tracker.sv
module rxdma_dualbuf_tracker
   import rxdma_pkg::*;
#(
   parameter int unsigned CNT_W      = 13,
   parameter int unsigned REG_W      = 32,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned FIFO_DEPTH = 4,
   parameter bit          OVF_SAT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dma_rst,
   input  logic [1:0]        load_req,
   input  logic [1:0]        unload_req,
   input  logic [1:0]        cnt_wr,
   input  logic [CNT_W-1:0]  cnt_wdata,
   input  logic [CNT_W-1:0]  len_a,
   input  logic [CNT_W-1:0]  len_b,
   input  logic [ADDR_W-1:0] base_a,
   input  logic [ADDR_W-1:0] base_b,
   input  logic              rx_valid,
   input  logic              rx_par_err,
   input  logic              rx_frm_err,
   input  logic              rx_ovf_err,
   input  logic              spi_slave,
   input  logic              ssel_n,
   output logic [REG_W-1:0]  rx_cnt_a,
   output logic [REG_W-1:0]  rx_cnt_b,
   output logic [REG_W-1:0]  err_off_a,
   output logic [REG_W-1:0]  err_off_b,
   output logic [REG_W-1:0]  saved_cnt,
   output logic [1:0]        loaded,
   output logic              drop_ovf,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_buf
);
   localparam int unsigned NBUF = RXDMA_NBUF;

   generate
      if (CNT_W < 2 || REG_W <= CNT_W || ADDR_W < CNT_W) begin : g_bad_width
         $error("rxdma_dualbuf_tracker: inconsistent widths");
      end
      if (FIFO_DEPTH < 1 || FIFO_DEPTH >= (1 << CNT_W)) begin : g_bad_depth
         $error("rxdma_dualbuf_tracker: FIFO_DEPTH out of range");
      end
   endgenerate

   rxdma_buf_e       active;
   rxdma_buf_e       target;
   logic             hit;
   rxdma_flags_t     flags;
   logic [CNT_W-1:0] cnt_v [NBUF];
   logic [CNT_W-1:0] err_v [NBUF];
   logic [NBUF-1:0]  loaded_v;
   logic [NBUF-1:0]  last_v;
   logic [CNT_W-1:0] snap_v;
   logic [CNT_W-1:0] cur_cnt;

   assign flags   = '{parity: rx_par_err, framing: rx_frm_err, overrun: rx_ovf_err};
   assign cur_cnt = cnt_v[active];

   rxdma_route #(
      .CNT_W (CNT_W),
      .ADDR_W(ADDR_W)
   ) u_route (
      .rx_valid(rx_valid),
      .active  (active),
      .loaded  (loaded_v),
      .cnt_a   (cnt_v[0]),
      .cnt_b   (cnt_v[1]),
      .base_a  (base_a),
      .base_b  (base_b),
      .hit     (hit),
      .target  (target),
      .addr    (mem_addr)
   );

   for (genvar gi = 0; gi < NBUF; gi++) begin : g_slot
      rxdma_buf_slot #(
         .CNT_W     (CNT_W),
         .FIFO_DEPTH(FIFO_DEPTH),
         .OVF_SAT   (OVF_SAT)
      ) u_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .dma_rst(dma_rst),
         .wr_en  (cnt_wr[gi]),
         .wr_data(cnt_wdata),
         .load   (load_req[gi]),
         .unload (unload_req[gi]),
         .byte_we(hit && (target == rxdma_buf_e'(gi))),
         .flags  (flags),
         .len    ((gi == 0) ? len_a : len_b),
         .cnt    (cnt_v[gi]),
         .loaded (loaded_v[gi]),
         .err_off(err_v[gi]),
         .last   (last_v[gi])
      );
   end

   rxdma_ssel_snap #(
      .CNT_W(CNT_W)
   ) u_snap (
      .clk      (clk),
      .rst_n    (rst_n),
      .dma_rst  (dma_rst),
      .spi_slave(spi_slave),
      .ssel_n   (ssel_n),
      .cur_cnt  (cur_cnt),
      .saved    (snap_v)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= BUF_A;
         drop_ovf <= 1'b0;
      end else if (dma_rst) begin
         active   <= BUF_A;
         drop_ovf <= 1'b0;
      end else begin
         if (hit) begin
            if (last_v[target]) begin
               active <= (target == BUF_A) ? BUF_B : BUF_A;
            end else begin
               active <= target;
            end
         end
         if (rx_valid && !hit) begin
            drop_ovf <= 1'b1;
         end
      end
   end

   assign rx_cnt_a  = REG_W'(cnt_v[0]);
   assign rx_cnt_b  = REG_W'(cnt_v[1]);
   assign err_off_a = REG_W'(err_v[0]);
   assign err_off_b = REG_W'(err_v[1]);
   assign saved_cnt = REG_W'(snap_v);
   assign loaded    = loaded_v;
   assign mem_we    = hit;
   assign mem_buf   = target;
endmodule

// File: rtl/rxdma_dualbuf_chk.sv
module rxdma_dualbuf_chk #(
   parameter int unsigned CNT_W = 13,
   parameter int unsigned REG_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dma_rst,
   input logic [1:0]       load_req,
   input logic [1:0]       unload_req,
   input logic [1:0]       cnt_wr,
   input logic [CNT_W-1:0] cnt_wdata,
   input logic             rx_valid,
   input logic             spi_slave,
   input logic             ssel_n,
   input logic [REG_W-1:0] rx_cnt_a,
   input logic [REG_W-1:0] rx_cnt_b,
   input logic [REG_W-1:0] err_off_a,
   input logic [REG_W-1:0] err_off_b,
   input logic [REG_W-1:0] saved_cnt,
   input logic [1:0]       loaded,
   input logic             drop_ovf,
   input logic             mem_we,
   input logic             mem_buf
);
   p_we_loaded_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> loaded[mem_buf]);

   p_drop_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && loaded == 2'b00 && !dma_rst) |=> drop_ovf);

   p_step_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !mem_buf && !dma_rst && !cnt_wr[0] && !load_req[0] && !unload_req[0])
      |=> rx_cnt_a[CNT_W-1:0] == CNT_W'($past(rx_cnt_a[CNT_W-1:0]) + 1'b1));

   p_load_clears_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req[0] && !cnt_wr[0] && !dma_rst) |=> (rx_cnt_a == '0 && err_off_a == '0 && loaded[0]));

   p_load_clears_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req[1] && !cnt_wr[1] && !dma_rst) |=> (rx_cnt_b == '0 && err_off_b == '0 && loaded[1]));

   p_write_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr[1] && !dma_rst) |=> (loaded[1] && rx_cnt_b == REG_W'($past(cnt_wdata))));

   p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_off_a != '0 && !dma_rst && !load_req[0] && !cnt_wr[0]) |=> err_off_a == $past(err_off_a));

   p_snap_on_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (saved_cnt != $past(saved_cnt)) |-> ($past(ssel_n) && $past(spi_slave)));

   p_dma_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dma_rst |=> (loaded == 2'b00 && rx_cnt_a == '0 && rx_cnt_b == '0 &&
                   err_off_a == '0 && err_off_b == '0 && !drop_ovf));
endmodule

bind rxdma_dualbuf_tracker rxdma_dualbuf_chk #(
   .CNT_W(CNT_W),
   .REG_W(REG_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dma_rst   (dma_rst),
   .load_req  (load_req),
   .unload_req(unload_req),
   .cnt_wr    (cnt_wr),
   .cnt_wdata (cnt_wdata),
   .rx_valid  (rx_valid),
   .spi_slave (spi_slave),
   .ssel_n    (ssel_n),
   .rx_cnt_a  (rx_cnt_a),
   .rx_cnt_b  (rx_cnt_b),
   .err_off_a (err_off_a),
   .err_off_b (err_off_b),
   .saved_cnt (saved_cnt),
   .loaded    (loaded),
   .drop_ovf  (drop_ovf),
   .mem_we    (mem_we),
   .mem_buf   (mem_buf)
);

// File: tb/rxdma_dualbuf_tracker_tb_top.sv
module rxdma_dualbuf_tracker_tb_top;
   localparam int CW = 13;
   localparam int AW = 16;
   localparam int RW = 32;
   localparam int DEPTH = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          dma_rst;
   logic [1:0]    load_req, unload_req, cnt_wr;
   logic [CW-1:0] cnt_wdata, len_a, len_b;
   logic [AW-1:0] base_a, base_b;
   logic          rx_valid, rx_par_err, rx_frm_err, rx_ovf_err;
   logic          spi_slave, ssel_n;
   logic [RW-1:0] rx_cnt_a, rx_cnt_b, err_off_a, err_off_b, saved_cnt;
   logic [1:0]    loaded;
   logic          drop_ovf, mem_we, mem_buf;
   logic [AW-1:0] mem_addr;

   always #2 clk = ~clk;

   rxdma_dualbuf_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .dma_rst(dma_rst), .load_req(load_req),
      .unload_req(unload_req), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
      .len_a(len_a), .len_b(len_b), .base_a(base_a), .base_b(base_b),
      .rx_valid(rx_valid), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
      .rx_ovf_err(rx_ovf_err), .spi_slave(spi_slave), .ssel_n(ssel_n),
      .rx_cnt_a(rx_cnt_a), .rx_cnt_b(rx_cnt_b), .err_off_a(err_off_a),
      .err_off_b(err_off_b), .saved_cnt(saved_cnt), .loaded(loaded),
      .drop_ovf(drop_ovf), .mem_we(mem_we), .mem_addr(mem_addr), .mem_buf(mem_buf)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference state built from the requirements
   logic [CW-1:0] m_cnt [2];
   logic [CW-1:0] m_err [2];
   logic          m_ld [2];
   logic          m_es [2];
   logic          m_act, m_drop, m_armed, m_ssq;
   logic [CW-1:0] m_saved;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [CW-1:0] exp_err_off(input logic [CW-1:0] c, input logic ovf);
      if (!ovf) return c;
      return (c >= CW'(DEPTH)) ? CW'(c - CW'(DEPTH)) : '0;
   endfunction

   task automatic m_route(output logic ok, output logic t);
      t  = m_ld[m_act] ? m_act : !m_act;
      ok = m_ld[t];
   endtask

   task automatic m_reset();
      for (int i = 0; i < 2; i++) begin
         m_cnt[i] = '0; m_err[i] = '0; m_ld[i] = 1'b0; m_es[i] = 1'b0;
      end
      m_act = 1'b0; m_drop = 1'b0;
   endtask

   task automatic m_update();
      logic ok, t, rise;
      logic [CW-1:0] cur, old_t, lt;
      m_route(ok, t);
      cur   = m_cnt[m_act];
      old_t = m_cnt[t];
      lt    = t ? len_b : len_a;
      if (dma_rst) begin
         m_reset();
         m_armed = 1'b1;
      end else begin
         rise = spi_slave && ssel_n && !m_ssq;
         if (rise && m_armed) begin
            m_saved = cur;
            m_armed = 1'b0;
         end
         if (rx_valid && !ok) m_drop = 1'b1;
         for (int i = 0; i < 2; i++) begin
            logic [CW-1:0] ln;
            ln = (i == 1) ? len_b : len_a;
            if (cnt_wr[i]) begin
               if (!m_ld[i]) begin m_err[i] = '0; m_es[i] = 1'b0; end
               m_cnt[i] = cnt_wdata;
               m_ld[i]  = 1'b1;
            end else if (load_req[i]) begin
               m_cnt[i] = '0; m_ld[i] = 1'b1; m_err[i] = '0; m_es[i] = 1'b0;
            end else if (unload_req[i]) begin
               m_ld[i] = 1'b0;
            end else if (rx_valid && ok && (t == i[0])) begin
               if ((rx_par_err || rx_frm_err || rx_ovf_err) && !m_es[i]) begin
                  m_err[i] = exp_err_off(m_cnt[i], rx_ovf_err);
                  m_es[i]  = 1'b1;
               end
               if (CW'(m_cnt[i] + 1'b1) == ln) m_ld[i] = 1'b0;
               m_cnt[i] = CW'(m_cnt[i] + 1'b1);
            end
         end
         if (rx_valid && ok) m_act = (CW'(old_t + 1'b1) == lt) ? !t : t;
      end
      m_ssq = ssel_n;
   endtask

   task automatic compare_all();
      chk("R1 offset A", rx_cnt_a, RW'(m_cnt[0]));
      chk("R1 offset B", rx_cnt_b, RW'(m_cnt[1]));
      chk("R6 error A", err_off_a, RW'(m_err[0]));
      chk("R6 error B", err_off_b, RW'(m_err[1]));
      chk("R5 saved", saved_cnt, RW'(m_saved));
      chk("R4 loaded", loaded, {m_ld[1], m_ld[0]});
      chk("R10 drop", drop_ovf, m_drop);
      chk("R8 reserved bits", {rx_cnt_a[RW-1:CW], rx_cnt_b[RW-1:CW], err_off_a[RW-1:CW],
                               err_off_b[RW-1:CW], saved_cnt[RW-1:CW]} == '0, 1'b1);
   endtask

   // inputs are set at a falling edge; combinational outputs checked before the rising edge
   task automatic tick();
      logic ok, t;
      #1;
      m_route(ok, t);
      chk("R10 write strobe", mem_we, rx_valid && ok);
      if (rx_valid && ok) begin
         chk("R1 address", mem_addr, (t ? base_b : base_a) + AW'(m_cnt[t]));
         chk("R4 target", mem_buf, t);
      end
      @(posedge clk);
      m_update();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle();
      dma_rst = 0; load_req = 0; unload_req = 0; cnt_wr = 0; cnt_wdata = 0;
      rx_valid = 0; rx_par_err = 0; rx_frm_err = 0; rx_ovf_err = 0;
   endtask

   task automatic rx_byte(input logic par, input logic frm, input logic ovf);
      rx_valid = 1; rx_par_err = par; rx_frm_err = frm; rx_ovf_err = ovf;
      tick();
      idle();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd7011));
      idle();
      rst_n = 0; spi_slave = 1; ssel_n = 1;
      len_a = 13'd8; len_b = 13'd10; base_a = 16'h1000; base_b = 16'h2000;
      m_reset(); m_armed = 1'b1; m_ssq = 1'b1; m_saved = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R8: reset values
      chk("R8 reset state", {rx_cnt_a, rx_cnt_b, err_off_a, err_off_b, saved_cnt} == '0, 1'b1);
      chk("R8 reset loaded/drop", {loaded, drop_ovf}, 3'b000);

      load_req = 2'b01; tick(); idle();
      chk("R2 load A", loaded, 2'b01);
      repeat (3) rx_byte(0, 0, 0);
      chk("R1 three bytes", rx_cnt_a, 3);
      rx_byte(1, 0, 0);
      chk("R6 parity offset", err_off_a, 3);
      rx_byte(0, 1, 0);
      chk("R7 later error ignored", err_off_a, 3);

      ssel_n = 0; tick(); ssel_n = 1; tick();
      chk("R5 first release", saved_cnt, 5);
      rx_byte(0, 0, 0);
      ssel_n = 0; tick(); ssel_n = 1; tick();
      chk("R5 second release ignored", saved_cnt, 5);

      rx_byte(0, 0, 0); rx_byte(0, 0, 0);
      chk("R4 length reached unloads", {loaded, rx_cnt_a[CW-1:0]}, {2'b00, 13'd8});
      rx_byte(0, 0, 0);
      chk("R10 dropped byte", {drop_ovf, rx_cnt_a[CW-1:0]}, {1'b1, 13'd8});

      cnt_wr = 2'b10; cnt_wdata = 13'd2; tick(); idle();
      chk("R3 write loads B", {loaded, rx_cnt_b[CW-1:0]}, {2'b10, 13'd2});
      repeat (3) rx_byte(0, 0, 0);
      rx_byte(0, 0, 1);
      chk("R6 overrun back-off", err_off_b, 1);

      load_req = 2'b01; tick(); idle();
      repeat (4) rx_byte(0, 0, 0);
      chk("R4 B full", {loaded, rx_cnt_b[CW-1:0]}, {2'b01, 13'd10});
      rx_byte(0, 0, 0);
      chk("R4 handover to A", rx_cnt_a, 1);

      load_req = 2'b10; tick(); idle();
      chk("R2 load clears error", {rx_cnt_b, err_off_b}, 64'd0);
      rx_byte(0, 0, 1);
      chk("R6 overrun floor at zero", err_off_a, 0);
      cnt_wr = 2'b01; cnt_wdata = 13'd7; load_req = 2'b01; tick(); idle();
      chk("R11 write beats load", rx_cnt_a, 7);
      unload_req = 2'b01; rx_valid = 1; tick(); idle();
      chk("R11 unload beats byte", {loaded[0], rx_cnt_a[CW-1:0]}, {1'b0, 13'd7});

      dma_rst = 1; tick(); idle();
      chk("R9 reset clears", {loaded, drop_ovf, rx_cnt_a[CW-1:0], rx_cnt_b[CW-1:0]}, 29'd0);
      chk("R9 saved kept", saved_cnt, 5);
      load_req = 2'b01; tick(); idle();
      repeat (3) rx_byte(0, 0, 0);
      ssel_n = 0; tick(); ssel_n = 1; tick();
      chk("R9 snapshot re-armed", saved_cnt, 3);

      // constrained random phase against the reference state
      len_a = 13'd20; len_b = 13'd13;
      for (int n = 0; n < 3000; n++) begin
         dma_rst    = ($urandom_range(60) == 0);
         load_req   = {($urandom_range(14) == 0), ($urandom_range(14) == 0)};
         unload_req = {($urandom_range(40) == 0), ($urandom_range(40) == 0)};
         cnt_wr     = {($urandom_range(50) == 0), ($urandom_range(50) == 0)};
         cnt_wdata  = CW'($urandom_range(15));
         rx_valid   = $urandom_range(1);
         rx_par_err = ($urandom_range(12) == 0);
         rx_frm_err = ($urandom_range(12) == 0);
         rx_ovf_err = ($urandom_range(10) == 0);
         spi_slave  = ($urandom_range(5) != 0);
         if ($urandom_range(7) == 0) ssel_n = ~ssel_n;
         if ($urandom_range(200) == 0) base_a = AW'($urandom);
         if ($urandom_range(200) == 0) base_b = AW'($urandom);
         tick();
      end
      idle();
      finish_run();
   end
endmodule